// File: doc/BRIEF.md
# Mesh Boundary Self-Test Sequencer

This block is the stimulus side of a built-in self-test for a square mesh network of routers. It sits at the edge of the mesh. It drives one test packet into each of the four boundary sides, north, west, south and east, for each of 26 fixed test configurations. Every packet carries a data word and a relative destination address. The data word is either the seed value `x` or its bitwise complement. Two force signals switch the routers into YX routing for a checkerboard half of the mesh.

The 26 configurations fall into three groups. Two straight-through configurations come first. Eight diagonal turning configurations follow, and they are the only ones that use the YX force signals. Sixteen resource-loopback configurations come last. In the loopback group, one side at a time is the active side and uses a one-hop address. Each packet is launched with a valid/ready handshake that is separate for each side, so the block works with links that run on another clock. After the last of the four sides has completed its transfer, a small pacing counter waits a fixed number of cycles before the next configuration is launched. Response compaction and the routers themselves are outside this block.

Top module: `mesh_bist_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a run, all side valids are 0, all side data and address buses are 0, both YX force signals are 0, the configuration index is 0 and `done` is 0.
- R2: A `start` pulse seen while idle or done launches configuration 0. Configurations are then visited strictly in the order 0, 1, …, 25, and `cfg_idx` shows the configuration being sent.
- R3: Side index order is N=3, W=2, S=1, E=0. Each address is `{x, y}` with each coordinate a two's-complement field of ADDR_W bits. In configurations 0 and 1 the data for N,W,S,E is x,~x,x,~x and its inverse. The addresses are N=(0,-n), W=(n,0), S=(0,n), E=(-n,0).
- R4: In configurations 2–9, even configurations send x,x,~x,~x on N,W,S,E and odd configurations send the inverse. In 2–5 the addresses are N=W=(n,-n) and S=E=(-n,n). In 6–9 they are N=E=(-n,-n) and W=S=(n,n).
- R5: `yx_force_a` is 1 exactly in configurations 2, 3, 6 and 7. `yx_force_b` is 1 exactly in 4, 5, 8 and 9. The two are never 1 together.
- R6: In configurations 10–25 the active side is N, W, S, E in turn, for two configurations each. In 10–17 the even configuration sends x on the active side and ~x on the others, and the odd one sends ~x on all four sides. In 18–25 the even configuration sends x on all four sides, and the odd one sends ~x on the active side only.
- R7: In configurations 10–25 the active side uses a one-hop address: N=(0,-1), W=(1,0), S=(0,-1), E=(1,0). The other sides keep the straight addresses of R3.
- R8: A side's valid stays high, with its data and address held stable, until that side's ready is sampled high. It then drops and stays low for the rest of that configuration.
- R9: After the clock edge that completes the last of the four transfers, the next configuration launches exactly PACE cycles later. PACE is n+1, or 2n+1 when IN_BUF=1. With ready held high, launches are therefore n+2 (or 2n+2) cycles apart.
- R10: After configuration 25 has paced out, `done` rises and all outputs return to their idle values. `start` is ignored while a run is in progress, and a new `start` clears `done` and begins again at configuration 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run |
| seed_x | input | DATA_W | Test value x |
| side_ready | input | 4 | Per-side ready from the mesh (N,W,S,E = 3..0) |
| side_valid | output | 4 | Per-side packet valid |
| side_data | output | 4*DATA_W | Per-side data word, side s at bits s*DATA_W |
| side_addr | output | 8*ADDR_W | Per-side `{x,y}` relative address, side s at bits s*2*ADDR_W |
| yx_force_a | output | 1 | YX routing force for the first checkerboard half |
| yx_force_b | output | 1 | YX routing force for the second checkerboard half |
| cfg_idx | output | 5 | Configuration being sent |
| done | output | 1 | Run complete |

## Verification
The full 26-configuration walk runs with every ready held high and the seed 0xA5C3. Its bits are asymmetric, so any swap between x and ~x, or any side sent to the wrong lane, shows up in the data word. The same walk checks the launch spacing, the order of addresses and the YX force values. A second run uses the seed 0x0F0F and holds the west ready low. This separates the holding of a stalled side from the release of the sides that have completed, and shows that the pacing waits for the slowest side. A second instance with input buffering enabled tells the two pacing lengths apart. A start pulse in the middle of the run, and a reset in the middle of a run, cover the ignore and recovery paths.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_PACE = 2'd2,
    PH_DONE = 2'd3
  } mbs_phase_e;

  localparam int unsigned NUM_CFG   = 26;
  localparam int unsigned NUM_SIDES = 4;
  localparam int unsigned IDX_W     = 5;
  localparam int unsigned SIDE_N    = 3;
  localparam int unsigned SIDE_W    = 2;
  localparam int unsigned SIDE_S    = 1;
  localparam int unsigned SIDE_E    = 0;

  // side bit (3..0) that is active in loopback configurations 10..25
  function automatic int unsigned active_side(input logic [IDX_W-1:0] idx);
    int unsigned k;
    k = ((int'(idx) - 10) / 2) % 4;
    return 3 - k;
  endfunction

  // per-side complement flags, bit s set means side s carries ~x
  function automatic logic [3:0] cfg_invert(input logic [IDX_W-1:0] idx);
    logic [3:0] act;
    if (idx < 5'd2) begin
      return idx[0] ? 4'b1010 : 4'b0101;
    end else if (idx < 5'd10) begin
      return idx[0] ? 4'b1100 : 4'b0011;
    end
    act = 4'b0001 << active_side(idx);
    if (idx < 5'd18) return idx[0] ? 4'b1111 : ~act;
    return idx[0] ? act : 4'b0000;
  endfunction

  // {force_b, force_a}
  function automatic logic [1:0] cfg_yx(input logic [IDX_W-1:0] idx);
    int unsigned grp;
    if (idx < 5'd2 || idx > 5'd9) return 2'b00;
    grp = (int'(idx) - 2) / 2;
    return (grp % 2 == 1) ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/mbs_pacer.sv
module mbs_pacer #(
  parameter int unsigned LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (kick) begin
      cnt_q <= '0;
    end else if (run && !expire) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign expire = run && (cnt_q == CW'(LIMIT - 1));

  // R9
  pace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/mbs_side_lane.sv
module mbs_side_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  clear,
  input  logic [DATA_W-1:0]     data_in,
  input  logic [2*ADDR_W-1:0]   addr_in,
  input  logic                  ready,
  output logic                  valid,
  output logic [DATA_W-1:0]     data_out,
  output logic [2*ADDR_W-1:0]   addr_out,
  output logic                  fin
);
  logic                pend_q;
  logic [DATA_W-1:0]   data_q;
  logic [2*ADDR_W-1:0] addr_q;
  logic                hs_evt;

  assign hs_evt = pend_q && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
      addr_q <= '0;
    end else if (clear) begin
      pend_q <= 1'b0;
      data_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      data_q <= data_in;
      addr_q <= addr_in;
    end else if (hs_evt) begin
      pend_q <= 1'b0;
    end
  end

  assign valid    = pend_q;
  assign data_out = data_q;
  assign addr_out = addr_q;
  assign fin      = !pend_q || hs_evt;

  // R8
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !clear) |=> (valid && $stable(data_out) && $stable(addr_out)));

  // R8
  drop_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_evt && !load) |=> !valid);

endmodule

// File: rtl/mbs_cfg_decode.sv
module mbs_cfg_decode
  import mbs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned MESH_N = 4
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic [DATA_W-1:0]         seed,
  output logic [4*DATA_W-1:0]       data_all,
  output logic [8*ADDR_W-1:0]       addr_all,
  output logic [1:0]                yx
);
  localparam int NN = int'(MESH_N);

  function automatic logic [2*ADDR_W-1:0] pack_xy(input int x, input int y);
    logic [ADDR_W-1:0] xs;
    logic [ADDR_W-1:0] ys;
    xs = ADDR_W'(x);
    ys = ADDR_W'(y);
    return {xs, ys};
  endfunction

  function automatic logic [2*ADDR_W-1:0] side_coord(input logic [IDX_W-1:0] i,
                                                     input int unsigned side);
    int x;
    int y;
    case (side)
      SIDE_N:  begin x = 0;   y = -NN; end
      SIDE_W:  begin x = NN;  y = 0;   end
      SIDE_S:  begin x = 0;   y = NN;  end
      default: begin x = -NN; y = 0;   end
    endcase
    if (i >= 5'd2 && i <= 5'd5) begin
      if (side >= SIDE_W) begin x = NN;  y = -NN; end
      else                begin x = -NN; y = NN;  end
    end else if (i >= 5'd6 && i <= 5'd9) begin
      if (side == SIDE_N || side == SIDE_E) begin x = -NN; y = -NN; end
      else                                  begin x = NN;  y = NN;  end
    end else if (i >= 5'd10 && side == active_side(i)) begin
      if (side == SIDE_N || side == SIDE_S) begin x = 0; y = -1; end
      else                                  begin x = 1; y = 0;  end
    end
    return pack_xy(x, y);
  endfunction

  logic [3:0] inv_vec;
  assign inv_vec = cfg_invert(idx);
  assign yx      = cfg_yx(idx);

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    assign data_all[s*DATA_W +: DATA_W]     = inv_vec[s] ? ~seed : seed;
    assign addr_all[s*2*ADDR_W +: 2*ADDR_W] = side_coord(idx, s);
  end

endmodule

// File: rtl/mesh_bist_seq.sv
module mesh_bist_seq
  import mbs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MESH_N = 4,
  parameter int unsigned ADDR_W = $clog2(MESH_N + 1) + 1,
  parameter bit          IN_BUF = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [DATA_W-1:0]     seed_x,
  input  logic [3:0]            side_ready,
  output logic [3:0]            side_valid,
  output logic [4*DATA_W-1:0]   side_data,
  output logic [8*ADDR_W-1:0]   side_addr,
  output logic                  yx_force_a,
  output logic                  yx_force_b,
  output logic [4:0]            cfg_idx,
  output logic                  done
);
  localparam int unsigned PACE_CYC = IN_BUF ? (2 * MESH_N + 1) : (MESH_N + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CFG - 1);

  mbs_phase_e       phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       yx_q;
  logic             done_q;

  logic             start_evt;
  logic             send_done_evt;
  logic             adv_evt;
  logic             finish_evt;
  logic             launch_evt;
  logic             pace_exp;
  logic             all_fin;
  logic [IDX_W-1:0] idx_launch;
  logic [3:0]       lane_fin;
  logic [4*DATA_W-1:0] dec_data;
  logic [8*ADDR_W-1:0] dec_addr;
  logic [1:0]          dec_yx;

  assign start_evt     = start && (phase_q == PH_IDLE || phase_q == PH_DONE);
  assign all_fin       = &lane_fin;
  assign send_done_evt = (phase_q == PH_SEND) && all_fin;
  assign adv_evt       = (phase_q == PH_PACE) && pace_exp && (idx_q != LAST_IDX);
  assign finish_evt    = (phase_q == PH_PACE) && pace_exp && (idx_q == LAST_IDX);
  assign launch_evt    = start_evt || adv_evt;
  assign idx_launch    = start_evt ? '0 : idx_q + IDX_W'(1);

  mbs_cfg_decode #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .MESH_N (MESH_N)
  ) u_decode (
    .idx      (idx_launch),
    .seed     (seed_x),
    .data_all (dec_data),
    .addr_all (dec_addr),
    .yx       (dec_yx)
  );

  mbs_pacer #(
    .LIMIT (PACE_CYC)
  ) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (send_done_evt),
    .run    (phase_q == PH_PACE),
    .expire (pace_exp)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_lane
    mbs_side_lane #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch_evt),
      .clear    (finish_evt),
      .data_in  (dec_data[s*DATA_W +: DATA_W]),
      .addr_in  (dec_addr[s*2*ADDR_W +: 2*ADDR_W]),
      .ready    (side_ready[s]),
      .valid    (side_valid[s]),
      .data_out (side_data[s*DATA_W +: DATA_W]),
      .addr_out (side_addr[s*2*ADDR_W +: 2*ADDR_W]),
      .fin      (lane_fin[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      yx_q    <= 2'b00;
      done_q  <= 1'b0;
    end else begin
      if (launch_evt) begin
        phase_q <= PH_SEND;
        idx_q   <= idx_launch;
        yx_q    <= dec_yx;
        done_q  <= 1'b0;
      end else if (send_done_evt) begin
        phase_q <= PH_PACE;
      end else if (finish_evt) begin
        phase_q <= PH_DONE;
        idx_q   <= '0;
        yx_q    <= 2'b00;
        done_q  <= 1'b1;
      end
    end
  end

  assign yx_force_a = yx_q[0];
  assign yx_force_b = yx_q[1];
  assign cfg_idx    = idx_q;
  assign done       = done_q;

  // R2
  cfg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (idx_q == '0 && side_valid == 4'b1111));

  // R5
  yx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({yx_force_a, yx_force_b}));

  // R9
  no_early_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_done_evt |=> (side_valid == 4'b0000));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (side_valid == 4'b0000 && !yx_force_a && !yx_force_b));

  // R10
  busy_ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase_q == PH_PACE && !pace_exp) |=> (idx_q == $past(idx_q)));

endmodule

// File: tb/mesh_bist_seq_tb.sv
module mesh_bist_seq_tb;
  localparam int DW = 16;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int P  = N + 1;
  localparam int PB = 2 * N + 1;

  // {invert N W S E [8:5], addr mode [4:2], {force_b, force_a} [1:0]}
  // addr mode: 0 straight, 1 turn group A, 2 turn group B, 3..6 active side N,W,S,E
  localparam logic [8:0] CFG_TBL [26] = '{
    {4'b0101, 3'd0, 2'b00}, {4'b1010, 3'd0, 2'b00},
    {4'b0011, 3'd1, 2'b01}, {4'b1100, 3'd1, 2'b01},
    {4'b0011, 3'd1, 2'b10}, {4'b1100, 3'd1, 2'b10},
    {4'b0011, 3'd2, 2'b01}, {4'b1100, 3'd2, 2'b01},
    {4'b0011, 3'd2, 2'b10}, {4'b1100, 3'd2, 2'b10},
    {4'b0111, 3'd3, 2'b00}, {4'b1111, 3'd3, 2'b00},
    {4'b1011, 3'd4, 2'b00}, {4'b1111, 3'd4, 2'b00},
    {4'b1101, 3'd5, 2'b00}, {4'b1111, 3'd5, 2'b00},
    {4'b1110, 3'd6, 2'b00}, {4'b1111, 3'd6, 2'b00},
    {4'b0000, 3'd3, 2'b00}, {4'b1000, 3'd3, 2'b00},
    {4'b0000, 3'd4, 2'b00}, {4'b0100, 3'd4, 2'b00},
    {4'b0000, 3'd5, 2'b00}, {4'b0010, 3'd5, 2'b00},
    {4'b0000, 3'd6, 2'b00}, {4'b0001, 3'd6, 2'b00}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [DW-1:0] seed;
  logic [3:0]    ready;
  logic [3:0]    valid;
  logic [4*DW-1:0] data;
  logic [8*AW-1:0] addr;
  logic          yxa, yxb, done;
  logic [4:0]    cidx;

  logic [3:0]    ib_valid;
  logic [4*DW-1:0] ib_data;
  logic [8*AW-1:0] ib_addr;
  logic          ib_yxa, ib_yxb, ib_done;
  logic [4:0]    ib_cidx;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ib_t [2];
  int ib_seen = 0;
  logic ib_prev = 1'b0;

  always #2 clk = ~clk;

  mesh_bist_seq #(.DATA_W(DW), .MESH_N(N), .ADDR_W(AW), .IN_BUF(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_x(seed), .side_ready(ready),
    .side_valid(valid), .side_data(data), .side_addr(addr),
    .yx_force_a(yxa), .yx_force_b(yxb), .cfg_idx(cidx), .done(done));

  mesh_bist_seq #(.DATA_W(DW), .MESH_N(N), .ADDR_W(AW), .IN_BUF(1'b1)) u_dut_ib (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_x(seed), .side_ready(4'hF),
    .side_valid(ib_valid), .side_data(ib_data), .side_addr(ib_addr),
    .yx_force_a(ib_yxa), .yx_force_b(ib_yxb), .cfg_idx(ib_cidx), .done(ib_done));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ib_valid[3] && !ib_prev && ib_seen < 2) begin
      ib_t[ib_seen] = cyc;
      ib_seen = ib_seen + 1;
    end
    ib_prev = ib_valid[3];
  end

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2*AW-1:0] exp_addr(input int mode, input int side);
    int x, y;
    logic [AW-1:0] xs, ys;
    if (mode >= 3 && side == 6 - mode) begin
      if (side == 3 || side == 1) begin x = 0; y = -1; end
      else begin x = 1; y = 0; end
    end else if (mode == 1) begin
      x = (side >= 2) ? N : -N;
      y = -x;
    end else if (mode == 2) begin
      x = (side == 2 || side == 1) ? N : -N;
      y = x;
    end else begin
      case (side)
        3: begin x = 0;  y = -N; end
        2: begin x = N;  y = 0;  end
        1: begin x = 0;  y = N;  end
        default: begin x = -N; y = 0; end
      endcase
    end
    xs = x[AW-1:0];
    ys = y[AW-1:0];
    return {xs, ys};
  endfunction

  task automatic wait_valid(output int w);
    w = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      w++;
      if (valid[3]) break;
    end
  endtask

  task automatic check_cfg(input int k);
    logic [8:0] e;
    e = CFG_TBL[k];
    chk("R2", "cfg_idx", cidx, k);
    chk("R8", "valid launch", valid, 4'hF);
    for (int s = 0; s < 4; s++) begin
      logic [DW-1:0] ed;
      ed = e[5 + s] ? ~seed : seed;
      chk(k < 2 ? "R3" : (k < 10 ? "R4" : "R6"), $sformatf("data cfg%0d side%0d", k, s),
          data[s*DW +: DW], ed);
      chk(k < 2 ? "R3" : (k < 10 ? "R4" : "R7"), $sformatf("addr cfg%0d side%0d", k, s),
          addr[s*2*AW +: 2*AW], exp_addr(int'(e[4:2]), s));
    end
    chk("R5", $sformatf("yx cfg%0d", k), {yxb, yxa}, e[1:0]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w;
    rst_n = 1'b0; start = 1'b0; ready = 4'hF; seed = 16'hA5C3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid", valid, 0);
    chk("R1", "done", done, 0);
    chk("R1", "data", data, 0);
    chk("R1", "addr", addr, 0);
    chk("R1", "yx", {yxb, yxa}, 0);
    chk("R1", "cfg_idx", cidx, 0);
    rst_n = 1'b1;

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check_cfg(0);
    for (int k = 1; k < 26; k++) begin
      int extra;
      extra = 0;
      if (k == 6) begin
        // R10: start pulse during a run is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        extra = 1;
      end
      wait_valid(w);
      chk("R9", $sformatf("launch spacing cfg%0d", k), w + extra, P + 1);
      check_cfg(k);
    end
    repeat (P) @(negedge clk);
    chk("R9", "done not early", done, 0);
    @(negedge clk);
    chk("R10", "done", done, 1);
    chk("R10", "valid idle", valid, 0);
    chk("R10", "data idle", data, 0);
    chk("R10", "yx idle", {yxb, yxa}, 0);
    repeat (4) @(negedge clk);
    chk("R10", "done held", done, 1);
    chk("R10", "valid held idle", valid, 0);

    chk("R9", "buffered spacing", (ib_seen == 2) ? (ib_t[1] - ib_t[0]) : 0, PB + 1);

    // handshake stall on west side, new seed, restart from done
    seed = 16'h0F0F; ready = 4'b1011;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10", "restart clears done", done, 0);
    chk("R2", "restart cfg", cidx, 0);
    chk("R3", "west data new seed", data[2*DW +: DW], 16'hF0F0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", "only stalled side valid", valid, 4'b0100);
      chk("R8", "stalled data stable", data[2*DW +: DW], 16'hF0F0);
      chk("R8", "stalled addr stable", addr[2*2*AW +: 2*AW], exp_addr(0, 2));
      chk("R9", "no advance while stalled", cidx, 0);
    end
    ready = 4'hF;
    wait_valid(w);
    chk("R9", "pace after slowest side", w, P + 1);
    chk("R2", "next cfg after stall", cidx, 1);

    // reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid reset valid", valid, 0);
    chk("R1", "mid reset cfg", cidx, 0);
    chk("R1", "mid reset data", data, 0);
    chk("R1", "mid reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule